// File: doc/BRIEF.md
# Module Presence-Detect Reader

This block brings up memory-module configuration at boot. On a start pulse it drives a byte-level two-wire (I2C) master engine through a fixed transaction. First it does a dummy write that sets the module EEPROM's internal pointer to zero. Then it issues a repeated-start sequential read of the 64 presence-detect bytes.

Each byte is decoded as it arrives, and a running checksum is kept. At the end the block holds the module parameters on its outputs and raises `done`, together with its error flags.

Every wait on the engine is bounded. If the engine stalls, the sequence is aborted with a sticky timeout flag and no further requests are made.

Top module: `spd_probe`

## Requirements
- R1: After reset and before any start pulse, `done`, `i2c_req`, `timeout_err` and `csum_err` are all 0.
- R2: A start pulse while idle or done begins a new sequence, whose first three requests are issued in this order, each advancing on `i2c_tx_empty`:
  - `i2c_start`=1, `i2c_stop`=0, `i2c_wdata`=0xA2 (device address with bit 0 = 0, write).
  - `i2c_start`=0, `i2c_stop`=0, `i2c_wdata`=0x00 (pointer reset).
  - `i2c_start`=1, `i2c_wdata`=0xA3 (device address with bit 0 = 1, read).
- R3: 64 read requests follow, each with `i2c_start`=0 and each advancing on `i2c_rx_full`, which captures `i2c_rdata`. The first 63 have `i2c_stop`=0 and `i2c_nack`=0. The 64th has `i2c_stop`=1 and `i2c_nack`=1. That makes 67 requests per sequence.
- R4: A handshake that arrives in the TIMEOUT_CYC-th cycle of a wait is accepted. If no handshake has arrived by then, the wait ends: `timeout_err`=1, `done`=1 and no further request is issued. `timeout_err` stays set until the next start.
- R5: `csum_err` is 1 exactly when the low 8 bits of the sum of bytes 0..62 differ from byte 63.
- R6: `refresh_code` is taken from bits 6:0 of byte 12:
  - value 1 gives code 1 (3.9 us);
  - value 2 gives code 2 (7.8 us);
  - any other value gives code 0 (15.6 us).
- R7: `is_x16` equals bit 4 of byte 13. `has_ecc` is 1 exactly when byte 11 equals 2.
- R8: `registered` equals bit 1 of byte 21.
- R9: `bank_count` equals bits 6:0 of byte 5. `bank_mb` equals byte 31 shifted left by 2. `total_bytes` equals `bank_mb` times `bank_count`, shifted left by 20.
- R10: Once `done` is 1, it and all result outputs hold unchanged until the next start pulse. A new start clears both error flags.
- R11: A start pulse during a running sequence is ignored: the sequence completes with the same 67 requests and the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read-and-parse sequence |
| i2c_req | output | 1 | One-cycle request to the byte engine |
| i2c_start | output | 1 | Request carries a (repeated) start condition |
| i2c_stop | output | 1 | Request ends with a stop condition |
| i2c_nack | output | 1 | Do not acknowledge the byte received |
| i2c_wdata | output | 8 | Byte to transmit for write requests |
| i2c_tx_empty | input | 1 | Engine finished sending a byte |
| i2c_rx_full | input | 1 | Engine received a byte on i2c_rdata |
| i2c_rdata | input | 8 | Received byte |
| done | output | 1 | Sequence finished or aborted |
| timeout_err | output | 1 | Sticky: a wait timed out |
| csum_err | output | 1 | Checksum mismatch |
| bank_count | output | 7 | Number of banks |
| is_x16 | output | 1 | Device width is x16 |
| has_ecc | output | 1 | Module has ECC |
| refresh_code | output | 2 | Refresh-rate code |
| registered | output | 1 | Module is registered |
| bank_mb | output | 10 | Bank size in MB |
| total_bytes | output | 37 | Total module size in bytes |

## Verification
The hardest situation to reach is a handshake that lands exactly on the last permitted cycle of a wait, and the case one cycle later. A single late response anywhere in the 67 waits decides between a full parse and an abort.

The bench's engine model answers after a programmable delay. Directed runs use a delay equal to TIMEOUT_CYC and TIMEOUT_CYC+1, and other runs hold back the response at a chosen write step and a chosen read step. Random images with random delays cover the decoding, including refresh values whose top bit is set.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int SPD_BYTES = 64;
  localparam int IDX_W     = $clog2(SPD_BYTES);
  localparam int BANK_W    = 7;
  localparam int MB_W      = 10;
  localparam int MB_SHIFT  = 20;
  localparam int TOTAL_W   = MB_W + BANK_W + MB_SHIFT;

  localparam logic [6:0] DEV_ADDR = 7'h51;

  localparam logic [IDX_W-1:0] IDX_BANKS = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_CFG   = IDX_W'(11);
  localparam logic [IDX_W-1:0] IDX_RFR   = IDX_W'(12);
  localparam logic [IDX_W-1:0] IDX_WIDTH = IDX_W'(13);
  localparam logic [IDX_W-1:0] IDX_ATTR  = IDX_W'(21);
  localparam logic [IDX_W-1:0] IDX_BSIZE = IDX_W'(31);
  localparam logic [IDX_W-1:0] IDX_CSUM  = IDX_W'(SPD_BYTES - 1);

  localparam int X16_BIT     = 4;
  localparam int ATTR_REG_BIT = 1;
  localparam logic [7:0] CFG_ECC = 8'd2;

  typedef enum logic [1:0] {
    RFR_15US6 = 2'd0,
    RFR_3US9  = 2'd1,
    RFR_7US8  = 2'd2
  } rfr_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/spd_wdog.sv
module spd_wdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = arm_i | run_i;
    cnt_d  = arm_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/spd_seq.sv
module spd_seq
  import spd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tx_empty_i,
  input  logic             rx_full_i,
  output logic             req_o,
  output logic             req_start_o,
  output logic             req_stop_o,
  output logic             req_nack_o,
  output logic [7:0]       wdata_o,
  output logic             byte_vld_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             clr_o,
  output logic             done_o,
  output logic             tout_o
);
  localparam int NWR    = 3;
  localparam int NSTEP  = SPD_BYTES + NWR;
  localparam int STEP_W = $clog2(NSTEP + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);
  localparam logic [STEP_W-1:0] RD_ADDR_STEP = STEP_W'(NWR - 1);

  seq_st_e           st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              tout_q, tout_d;
  logic              is_rd, hs, arm, expired, wait_run;

  assign is_rd    = step_q >= STEP_W'(NWR);
  assign hs       = is_rd ? rx_full_i : tx_empty_i;
  assign wait_run = (st_q == ST_WAIT);

  spd_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm),
    .run_i     (wait_run),
    .expired_o (expired)
  );

  always_comb begin
    st_d       = st_q;
    step_d     = step_q;
    tout_d     = tout_q;
    clr_o      = 1'b0;
    byte_vld_o = 1'b0;
    arm        = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_d   = ST_ISSUE;
          step_d = '0;
          tout_d = 1'b0;
          clr_o  = 1'b1;
        end
      end
      ST_ISSUE: begin
        st_d = ST_WAIT;
        arm  = 1'b1;
      end
      ST_WAIT: begin
        if (hs) begin
          byte_vld_o = is_rd;
          if (step_q == LAST_STEP) begin
            st_d = ST_DONE;
          end else begin
            step_d = step_q + STEP_W'(1);
            st_d   = ST_ISSUE;
          end
        end else if (expired) begin
          tout_d = 1'b1;
          st_d   = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      tout_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      tout_q <= tout_d;
    end
  end

  always_comb begin
    req_o       = (st_q == ST_ISSUE);
    req_start_o = req_o && (step_q == '0 || step_q == RD_ADDR_STEP);
    req_stop_o  = req_o && (step_q == LAST_STEP);
    req_nack_o  = req_o && (step_q == LAST_STEP);
    if (step_q == '0)               wdata_o = {DEV_ADDR, 1'b0};
    else if (step_q == RD_ADDR_STEP) wdata_o = {DEV_ADDR, 1'b1};
    else                            wdata_o = 8'h00;
  end

  assign byte_idx_o = IDX_W'(step_q - STEP_W'(NWR));
  assign done_o     = (st_q == ST_DONE);
  assign tout_o     = tout_q;
endmodule

// File: rtl/spd_decode.sv
module spd_decode
  import spd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               vld_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [7:0]         data_i,
  output logic [BANK_W-1:0]  bank_cnt_o,
  output logic               x16_o,
  output logic               ecc_o,
  output logic [1:0]         rfr_o,
  output logic               regd_o,
  output logic [MB_W-1:0]    bank_mb_o,
  output logic [TOTAL_W-1:0] total_o,
  output logic               csum_err_o
);
  logic [7:0]        sum_q, sum_d;
  logic [BANK_W-1:0] bc_q, bc_d;
  logic              x16_q, x16_d, ecc_q, ecc_d, regd_q, regd_d, cerr_q, cerr_d;
  logic [1:0]        rfr_q, rfr_d;
  logic [MB_W-1:0]   mb_q, mb_d;
  logic [MB_W+BANK_W-1:0] prod;

  always_comb begin
    sum_d  = sum_q;
    bc_d   = bc_q;
    x16_d  = x16_q;
    ecc_d  = ecc_q;
    regd_d = regd_q;
    cerr_d = cerr_q;
    rfr_d  = rfr_q;
    mb_d   = mb_q;
    if (clr_i) begin
      sum_d  = '0;
      bc_d   = '0;
      x16_d  = 1'b0;
      ecc_d  = 1'b0;
      regd_d = 1'b0;
      cerr_d = 1'b0;
      rfr_d  = RFR_15US6;
      mb_d   = '0;
    end else if (vld_i) begin
      if (idx_i != IDX_CSUM) sum_d = sum_q + data_i;
      case (idx_i)
        IDX_BANKS: bc_d   = data_i[BANK_W-1:0];
        IDX_CFG:   ecc_d  = (data_i == CFG_ECC);
        IDX_RFR: begin
          case (data_i[6:0])
            7'd1:    rfr_d = RFR_3US9;
            7'd2:    rfr_d = RFR_7US8;
            default: rfr_d = RFR_15US6;
          endcase
        end
        IDX_WIDTH: x16_d  = data_i[X16_BIT];
        IDX_ATTR:  regd_d = data_i[ATTR_REG_BIT];
        IDX_BSIZE: mb_d   = MB_W'({data_i, 2'b00});
        IDX_CSUM:  cerr_d = (data_i != sum_q);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      bc_q   <= '0;
      x16_q  <= 1'b0;
      ecc_q  <= 1'b0;
      regd_q <= 1'b0;
      cerr_q <= 1'b0;
      rfr_q  <= RFR_15US6;
      mb_q   <= '0;
    end else if (clr_i | vld_i) begin
      sum_q  <= sum_d;
      bc_q   <= bc_d;
      x16_q  <= x16_d;
      ecc_q  <= ecc_d;
      regd_q <= regd_d;
      cerr_q <= cerr_d;
      rfr_q  <= rfr_d;
      mb_q   <= mb_d;
    end
  end

  assign prod       = mb_q * bc_q;
  assign total_o    = {prod, {MB_SHIFT{1'b0}}};
  assign bank_cnt_o = bc_q;
  assign x16_o      = x16_q;
  assign ecc_o      = ecc_q;
  assign rfr_o      = rfr_q;
  assign regd_o     = regd_q;
  assign bank_mb_o  = mb_q;
  assign csum_err_o = cerr_q;
endmodule

// File: rtl/spd_probe.sv
module spd_probe
  import spd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               i2c_req,
  output logic               i2c_start,
  output logic               i2c_stop,
  output logic               i2c_nack,
  output logic [7:0]         i2c_wdata,
  input  logic               i2c_tx_empty,
  input  logic               i2c_rx_full,
  input  logic [7:0]         i2c_rdata,
  output logic               done,
  output logic               timeout_err,
  output logic               csum_err,
  output logic [BANK_W-1:0]  bank_count,
  output logic               is_x16,
  output logic               has_ecc,
  output logic [1:0]         refresh_code,
  output logic               registered,
  output logic [MB_W-1:0]    bank_mb,
  output logic [TOTAL_W-1:0] total_bytes
);
  logic             byte_vld, clr;
  logic [IDX_W-1:0] byte_idx;

  spd_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .tx_empty_i  (i2c_tx_empty),
    .rx_full_i   (i2c_rx_full),
    .req_o       (i2c_req),
    .req_start_o (i2c_start),
    .req_stop_o  (i2c_stop),
    .req_nack_o  (i2c_nack),
    .wdata_o     (i2c_wdata),
    .byte_vld_o  (byte_vld),
    .byte_idx_o  (byte_idx),
    .clr_o       (clr),
    .done_o      (done),
    .tout_o      (timeout_err)
  );

  spd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .vld_i      (byte_vld),
    .idx_i      (byte_idx),
    .data_i     (i2c_rdata),
    .bank_cnt_o (bank_count),
    .x16_o      (is_x16),
    .ecc_o      (has_ecc),
    .rfr_o      (refresh_code),
    .regd_o     (registered),
    .bank_mb_o  (bank_mb),
    .total_o    (total_bytes),
    .csum_err_o (csum_err)
  );
endmodule

// File: rtl/spd_probe_chk.sv
module spd_probe_chk
  import spd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               i2c_req,
  input logic               i2c_start,
  input logic               i2c_stop,
  input logic               i2c_nack,
  input logic [7:0]         i2c_wdata,
  input logic               done,
  input logic               timeout_err,
  input logic               csum_err,
  input logic [BANK_W-1:0]  bank_count,
  input logic [1:0]         refresh_code,
  input logic [TOTAL_W-1:0] total_bytes
);
  a_r2_addr_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_req && i2c_start |-> i2c_wdata[7:1] == DEV_ADDR);

  a_r3_stop_has_nack: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_req && i2c_stop |-> i2c_nack && !i2c_start);

  a_r3_nack_only_last: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_req && i2c_nack |-> i2c_stop);

  a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_req |=> !i2c_req);

  a_r4_tout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err && !start |=> timeout_err);

  a_r4_tout_means_done: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done && !i2c_req);

  a_r10_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> $stable(total_bytes) && $stable(csum_err)
                            && $stable(bank_count) && $stable(refresh_code));
endmodule

bind spd_probe spd_probe_chk u_chk (.*);

// File: tb/tb_spd_probe.sv
module tb_spd_probe;
  localparam int TO = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, tx_empty, rx_full;
  logic [7:0]  rdata;
  logic        i2c_req, i2c_start, i2c_stop, i2c_nack;
  logic [7:0]  i2c_wdata;
  logic        done, timeout_err, csum_err, is_x16, has_ecc, registered;
  logic [6:0]  bank_count;
  logic [1:0]  refresh_code;
  logic [9:0]  bank_mb;
  logic [36:0] total_bytes;

  spd_probe #(.TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .i2c_req(i2c_req), .i2c_start(i2c_start), .i2c_stop(i2c_stop),
    .i2c_nack(i2c_nack), .i2c_wdata(i2c_wdata),
    .i2c_tx_empty(tx_empty), .i2c_rx_full(rx_full), .i2c_rdata(rdata),
    .done(done), .timeout_err(timeout_err), .csum_err(csum_err),
    .bank_count(bank_count), .is_x16(is_x16), .has_ecc(has_ecc),
    .refresh_code(refresh_code), .registered(registered),
    .bank_mb(bank_mb), .total_bytes(total_bytes)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] mem [64];
  int resp_delay = 1;
  int hang_step = -1;
  int nreq = 0;
  int bad_req = 0;

  task automatic chk(input bit ok, input string r,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // byte-engine model: answers each request after resp_delay wait cycles
  initial begin
    tx_empty = 0; rx_full = 0; rdata = 0;
    forever begin
      if (rst_n !== 1'b1 || i2c_req !== 1'b1) @(negedge clk);
      else begin
        int s;
        bit es, el;
        logic [7:0] ew;
        if (i2c_start && i2c_wdata == 8'hA2) begin nreq = 0; bad_req = 0; end
        s  = nreq;
        es = (s == 0 || s == 2);
        el = (s == 66);
        ew = (s == 0) ? 8'hA2 : (s == 2) ? 8'hA3 : 8'h00;
        if (i2c_start !== es || i2c_stop !== el || i2c_nack !== el ||
            (s < 3 && i2c_wdata !== ew)) bad_req++;
        nreq++;
        if (s == hang_step || s > 66) @(negedge clk);
        else begin
          repeat (resp_delay) @(negedge clk);
          if (s < 3) tx_empty = 1;
          else begin rx_full = 1; rdata = mem[s-3]; end
          @(negedge clk);
          tx_empty = 0; rx_full = 0;
        end
      end
    end
  end

  task automatic seal_csum(input bit good);
    logic [7:0] s = 0;
    for (int i = 0; i < 63; i++) s += mem[i];
    mem[63] = good ? s : s ^ 8'(1 + ($urandom % 255));
  endtask

  task automatic run(input bit mid);
    int cyc = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 4000) begin
      start = (mid && cyc == 30);
      @(negedge clk);
      cyc++;
    end
    start = 0;
  endtask

  task automatic check_image(input string tag);
    logic [7:0]  s = 0;
    logic [6:0]  lo;
    logic [1:0]  er;
    logic [9:0]  emb;
    longint unsigned etot;
    for (int i = 0; i < 63; i++) s += mem[i];
    lo = mem[12][6:0];
    er = (lo == 7'd1) ? 2'd1 : (lo == 7'd2) ? 2'd2 : 2'd0;
    emb = {mem[31], 2'b00};
    etot = (longint'(emb) * longint'(mem[5][6:0])) << 20;
    chk(done === 1'b1, {"R10 done ", tag}, done, 1);
    chk(timeout_err === 1'b0, {"R4 no timeout ", tag}, timeout_err, 0);
    chk(nreq == 67, {"R3 request count ", tag}, nreq, 67);
    chk(bad_req == 0, {"R2 R3 request flags ", tag}, bad_req, 0);
    chk(csum_err === (s != mem[63]), {"R5 checksum ", tag}, csum_err, s != mem[63]);
    chk(refresh_code === er, {"R6 refresh ", tag}, refresh_code, er);
    chk(is_x16 === mem[13][4], {"R7 x16 ", tag}, is_x16, mem[13][4]);
    chk(has_ecc === (mem[11] == 8'd2), {"R7 ecc ", tag}, has_ecc, mem[11] == 8'd2);
    chk(registered === mem[21][1], {"R8 registered ", tag}, registered, mem[21][1]);
    chk(bank_count === mem[5][6:0], {"R9 banks ", tag}, bank_count, mem[5][6:0]);
    chk(bank_mb === emb, {"R9 bank mb ", tag}, bank_mb, emb);
    chk(total_bytes === 37'(etot), {"R9 total ", tag}, total_bytes, etot);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    longint unsigned hold_tot;
    seed = $urandom(32'h5D1A);
    rst_n = 0; start = 0;
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(done === 1'b0 && i2c_req === 1'b0, "R1 idle after reset", {done, i2c_req}, 0);
    chk(timeout_err === 1'b0 && csum_err === 1'b0, "R1 flags clear", {timeout_err, csum_err}, 0);

    // directed image, good checksum
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 3 + 1);
    mem[5] = 8'h82; mem[11] = 8'd2; mem[12] = 8'd2; mem[13] = 8'h10;
    mem[21] = 8'h02; mem[31] = 8'd32;
    seal_csum(1);
    resp_delay = 1;
    run(0);
    check_image("directed good");
    hold_tot = total_bytes;
    repeat (20) @(negedge clk);
    chk(done === 1'b1 && total_bytes === 37'(hold_tot) && i2c_req === 1'b0,
        "R10 results held", total_bytes, hold_tot);

    // directed image, bad checksum, response in the last permitted wait cycle
    mem[11] = 8'd0; mem[12] = 8'h82; mem[13] = 8'h0F; mem[21] = 8'hFD; mem[31] = 8'd255;
    mem[5] = 8'd127;
    seal_csum(0);
    resp_delay = TO;
    run(0);
    check_image("boundary delay");
    chk(csum_err === 1'b1, "R5 corrupted checksum flagged", csum_err, 1);

    // random images
    for (int k = 0; k < 8; k++) begin
      int unsigned r;
      for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
      r = $urandom % 6;
      mem[12] = (r < 3) ? 8'(r) : (r == 3) ? 8'h81 : 8'($urandom);
      mem[11] = ($urandom % 2) ? 8'd2 : 8'($urandom);
      mem[5]  = 8'(1 + $urandom % 4);
      seal_csum($urandom % 2);
      resp_delay = 1 + int'($urandom % TO);
      run(0);
      check_image($sformatf("random %0d", k));
    end

    // stall during a write step
    hang_step = 1; resp_delay = 1;
    run(0);
    chk(timeout_err === 1'b1 && done === 1'b1, "R4 timeout on write", {timeout_err, done}, 3);
    chk(nreq == 2, "R4 no request after write timeout", nreq, 2);
    repeat (10) @(negedge clk);
    chk(timeout_err === 1'b1 && nreq == 2, "R4 timeout sticky", {timeout_err, 8'(nreq)}, 16'h0102);

    // stall during a read step
    hang_step = 40;
    run(0);
    chk(timeout_err === 1'b1 && nreq == 41, "R4 timeout on read", nreq, 41);

    // response one cycle too late
    hang_step = -1; resp_delay = TO + 1;
    run(0);
    chk(timeout_err === 1'b1 && nreq == 1, "R4 late by one cycle", nreq, 1);
    repeat (TO + 4) @(negedge clk);

    // restart clears the error
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    mem[5] = 8'd2; seal_csum(1);
    resp_delay = 2;
    run(0);
    chk(timeout_err === 1'b0 && csum_err === 1'b0, "R10 restart clears errors",
        {timeout_err, csum_err}, 0);
    check_image("after restart");

    // start pulse mid-sequence
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    mem[12] = 8'd1; mem[5] = 8'd1; seal_csum(1);
    resp_delay = 3;
    run(1);
    check_image("R11 start while busy");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule